// File: doc/BRIEF.md
# AXI Read/Write Ordering Gate

This block sits between an AXI4 master and a memory controller. It gives
write-before-read and read-before-write ordering for transactions that share
an ID. Plain AXI gives no such ordering across directions. The block keeps a
count of unfinished writes and unfinished reads for every ID.

A new read address waits while writes with its ID are still open. A new write
address waits while reads with its ID are still open. A write finishes when
its response handshakes. A read finishes when its final data beat handshakes.

The write data, write response and read data channels go straight through
with no logic in the path. The two address channels are only gated: their
payload is wired through, and VALID toward the controller and READY toward
the master are masked while an address must wait. Reset is synchronous and
active high.

Top module: `axi_order_gate`

## Requirements
- R1: A cycle with `rst` high clears every count. After it, a read or write address for any ID is forwarded at once.
- R2: An address that is free to go reaches the controller in the same cycle. VALID, ID and address pass unchanged, and READY toward the master equals the controller's READY.
- R3: While any write with ID n lacks its write response, a read address with ID n is held: `m_arvalid` and `s_arready` are low. It is forwarded in the cycle after the B handshake that closes the last such write.
- R4: While any read with ID n lacks its final beat, a write address with ID n is held. A read data beat with `rlast` low does not release it. It is forwarded in the cycle after the beat with `rlast` high completes.
- R5: Open transactions of one ID never hold back an address of a different ID.
- R6: Addresses of the same ID in the same direction are never held back by each other until the saturation limit.
- R7: If a read address and a write address with the same ID both arrive fresh in one cycle and both could go, the write is forwarded and the read is held.
- R8: Once `m_awvalid` or `m_arvalid` is high, it stays high with an unchanged payload until the controller accepts it, as long as the master keeps its VALID high. This holds even when an opposite-direction address with the same ID arrives meanwhile.
- R9: Each per-ID count saturates at `MAX_OUT`, which defaults to 15. While the write count of ID n is full, further write addresses for n are held until a response for n completes. Reads behave the same way.
- R10: The W, B and R channels pass through unchanged: payload, VALID and READY, in both directions, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_awid | input | ID_W | Write address ID from master |
| s_awaddr | input | ADDR_W | Write address from master |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | DATA_W | Write data from master |
| s_wlast | input | 1 | Last write beat from master |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_bid | output | ID_W | Write response ID to master |
| s_bresp | output | 2 | Write response code to master |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_arid | input | ID_W | Read address ID from master |
| s_araddr | input | ADDR_W | Read address from master |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| s_rid | output | ID_W | Read data ID to master |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| s_rlast | output | 1 | Final read beat to master |
| m_awvalid | output | 1 | Write address valid to controller |
| m_awready | input | 1 | Write address ready from controller |
| m_awid | output | ID_W | Write address ID to controller |
| m_awaddr | output | ADDR_W | Write address to controller |
| m_wvalid | output | 1 | Write data valid to controller |
| m_wready | input | 1 | Write data ready from controller |
| m_wdata | output | DATA_W | Write data to controller |
| m_wlast | output | 1 | Last write beat to controller |
| m_bvalid | input | 1 | Write response valid from controller |
| m_bready | output | 1 | Write response ready to controller |
| m_bid | input | ID_W | Write response ID from controller |
| m_bresp | input | 2 | Write response code from controller |
| m_arvalid | output | 1 | Read address valid to controller |
| m_arready | input | 1 | Read address ready from controller |
| m_arid | output | ID_W | Read address ID to controller |
| m_araddr | output | ADDR_W | Read address to controller |
| m_rvalid | input | 1 | Read data valid from controller |
| m_rready | output | 1 | Read data ready to controller |
| m_rid | input | ID_W | Read data ID from controller |
| m_rdata | input | DATA_W | Read data from controller |
| m_rresp | input | 2 | Read response code from controller |
| m_rlast | input | 1 | Final read beat from controller |

## Verification
The bench sends a read burst with a beat whose `rlast` is low. A gate that closed reads on any beat would release a waiting same-ID write too early.

It presents a read that the controller stalls, then brings in a same-ID write. A gate that gave the write priority without exception would drop `m_arvalid` before the handshake.

It fills one ID's write count to the limit. A counter that wraps, or a limit that stalls one address early or late, shows up there.

It also checks that a reset clears open work, and that a same-cycle collision resolves to the write.

// File: rtl/axi_ord_pkg.sv
package axi_ord_pkg;

  // Per-ID counter update, encoded as {increment, decrement}
  typedef enum logic [1:0] {
    CNT_IDLE = 2'b00,
    CNT_DOWN = 2'b01,
    CNT_UP   = 2'b10,
    CNT_BOTH = 2'b11
  } cnt_op_e;

  // Bits needed to hold 0..max_val
  function automatic int cnt_w(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ord_cnt_bank.sv
module ord_cnt_bank
  import axi_ord_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int MAX_OUT = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc,
  input  logic [ID_W-1:0]       inc_id,
  input  logic                  dec,
  input  logic [ID_W-1:0]       dec_id,
  output logic [(1<<ID_W)-1:0]  idle_o,
  output logic [(1<<ID_W)-1:0]  full_o
);

  localparam int NID = 1 << ID_W;
  localparam int CW  = cnt_w(MAX_OUT);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_OUT);

  for (genvar g = 0; g < NID; g++) begin : g_id
    logic [CW-1:0] cnt;
    cnt_op_e       op;

    always_comb begin
      op = cnt_op_e'({inc && (inc_id == ID_W'(g)), dec && (dec_id == ID_W'(g))});
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else begin
        case (op)
          CNT_UP:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          CNT_DOWN: if (cnt != '0)      cnt <= cnt - 1'b1;
          default:  ;
        endcase
      end
    end

    assign idle_o[g] = (cnt == '0);
    assign full_o[g] = (cnt == CNT_MAX);

    // R9
    cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_MAX);

    // R9
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
      full_o[g] |-> (op != CNT_UP));
  end

endmodule

// File: rtl/ord_issue_ctl.sv
module ord_issue_ctl #(
  parameter int ID_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  aw_req,
  input  logic [ID_W-1:0]       aw_id,
  input  logic                  aw_acc,
  input  logic                  ar_req,
  input  logic [ID_W-1:0]       ar_id,
  input  logic                  ar_acc,
  input  logic [(1<<ID_W)-1:0]  wr_idle,
  input  logic [(1<<ID_W)-1:0]  wr_full,
  input  logic [(1<<ID_W)-1:0]  rd_idle,
  input  logic [(1<<ID_W)-1:0]  rd_full,
  output logic                  aw_go,
  output logic                  ar_go
);

  logic aw_open, ar_open, same_id;
  logic aw_hold, ar_hold;   // address shown to controller, not yet taken

  always_comb begin
    aw_open = rd_idle[aw_id] && !wr_full[aw_id];
    ar_open = wr_idle[ar_id] && !rd_full[ar_id];
    same_id = aw_req && ar_req && (aw_id == ar_id);
    // a read already on the bus keeps it; otherwise writes win a same-ID tie
    aw_go   = aw_req && aw_open && !(same_id && ar_hold);
    ar_go   = ar_req && ar_open && !(same_id && aw_go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_hold <= 1'b0;
      ar_hold <= 1'b0;
    end else begin
      aw_hold <= aw_go && !aw_acc;
      ar_hold <= ar_go && !ar_acc;
    end
  end

  // R8
  aw_keep_chk: assert property (@(posedge clk) disable iff (rst)
    aw_hold && aw_req |-> aw_go);

  // R8
  ar_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ar_hold && ar_req |-> ar_go);

  // R7
  same_id_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(aw_go && ar_go && (aw_id == ar_id)));

endmodule

// File: rtl/axi_order_gate.sv
module axi_order_gate #(
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ID_W-1:0]   m_arid,
  output logic [ADDR_W-1:0] m_araddr,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [ID_W-1:0]   m_rid,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast
);

  localparam int NID = 1 << ID_W;

  logic [NID-1:0] wr_idle, wr_full, rd_idle, rd_full;
  logic           aw_go, ar_go;
  logic           aw_fire, ar_fire, b_fire, rlast_fire;

  // Address channels: payload wired, VALID/READY gated
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awvalid = aw_go;
  assign s_awready = aw_go && m_awready;
  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arvalid = ar_go;
  assign s_arready = ar_go && m_arready;

  // Data and response channels: straight wires
  assign m_wvalid = s_wvalid;
  assign s_wready = m_wready;
  assign m_wdata  = s_wdata;
  assign m_wlast  = s_wlast;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign s_rid    = m_rid;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;

  assign aw_fire    = m_awvalid && m_awready;
  assign ar_fire    = m_arvalid && m_arready;
  assign b_fire     = m_bvalid && s_bready;
  assign rlast_fire = m_rvalid && s_rready && m_rlast;

  ord_issue_ctl #(.ID_W(ID_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .aw_req  (s_awvalid),
    .aw_id   (s_awid),
    .aw_acc  (m_awready),
    .ar_req  (s_arvalid),
    .ar_id   (s_arid),
    .ar_acc  (m_arready),
    .wr_idle (wr_idle),
    .wr_full (wr_full),
    .rd_idle (rd_idle),
    .rd_full (rd_full),
    .aw_go   (aw_go),
    .ar_go   (ar_go)
  );

  ord_cnt_bank #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u_wr_bank (
    .clk    (clk),
    .rst    (rst),
    .inc    (aw_fire),
    .inc_id (s_awid),
    .dec    (b_fire),
    .dec_id (m_bid),
    .idle_o (wr_idle),
    .full_o (wr_full)
  );

  ord_cnt_bank #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u_rd_bank (
    .clk    (clk),
    .rst    (rst),
    .inc    (ar_fire),
    .inc_id (s_arid),
    .dec    (rlast_fire),
    .dec_id (m_rid),
    .idle_o (rd_idle),
    .full_o (rd_full)
  );

  // R3
  ar_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> wr_idle[m_arid]);

  // R4
  aw_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> rd_idle[m_awid]);

  // R8
  aw_stable_chk: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready && s_awvalid |=> m_awvalid && $stable(m_awaddr) && $stable(m_awid));

endmodule

// File: tb/axi_order_gate_tb.sv
`timescale 1ns/1ps
module axi_order_gate_tb;

  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, MAX_OUT = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic s_awvalid = 0, s_awready; logic [ID_W-1:0] s_awid = '0; logic [ADDR_W-1:0] s_awaddr = '0;
  logic s_wvalid = 0, s_wready; logic [DATA_W-1:0] s_wdata = '0; logic s_wlast = 0;
  logic s_bvalid, s_bready = 0; logic [ID_W-1:0] s_bid; logic [1:0] s_bresp;
  logic s_arvalid = 0, s_arready; logic [ID_W-1:0] s_arid = '0; logic [ADDR_W-1:0] s_araddr = '0;
  logic s_rvalid, s_rready = 0; logic [ID_W-1:0] s_rid; logic [DATA_W-1:0] s_rdata;
  logic [1:0] s_rresp; logic s_rlast;
  logic m_awvalid, m_awready = 0; logic [ID_W-1:0] m_awid; logic [ADDR_W-1:0] m_awaddr;
  logic m_wvalid, m_wready = 0; logic [DATA_W-1:0] m_wdata; logic m_wlast;
  logic m_bvalid = 0, m_bready; logic [ID_W-1:0] m_bid = '0; logic [1:0] m_bresp = '0;
  logic m_arvalid, m_arready = 0; logic [ID_W-1:0] m_arid; logic [ADDR_W-1:0] m_araddr;
  logic m_rvalid = 0, m_rready; logic [ID_W-1:0] m_rid = '0; logic [DATA_W-1:0] m_rdata = '0;
  logic [1:0] m_rresp = '0; logic m_rlast = 0;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  axi_order_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u_dut (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rlast(s_rlast),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid), .m_rdata(m_rdata),
    .m_rresp(m_rresp), .m_rlast(m_rlast)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Write address handshake; checks that it is forwarded at once
  task automatic aw_hs(input int id, input string req);
    @(negedge clk);
    s_awvalid = 1; s_awid = ID_W'(id); s_awaddr = 32'h1000 + id; m_awready = 1;
    #1 chk(req, "m_awvalid", m_awvalid, 1);
    @(negedge clk);
    s_awvalid = 0; m_awready = 0;
  endtask

  task automatic ar_hs(input int id, input string req);
    @(negedge clk);
    s_arvalid = 1; s_arid = ID_W'(id); s_araddr = 32'h2000 + id; m_arready = 1;
    #1 chk(req, "m_arvalid", m_arvalid, 1);
    @(negedge clk);
    s_arvalid = 0; m_arready = 0;
  endtask

  task automatic b_hs(input int id);
    @(negedge clk);
    m_bvalid = 1; m_bid = ID_W'(id); s_bready = 1;
    @(negedge clk);
    m_bvalid = 0; s_bready = 0;
  endtask

  task automatic r_hs(input int id, input logic last);
    @(negedge clk);
    m_rvalid = 1; m_rid = ID_W'(id); m_rlast = last; s_rready = 1;
    @(negedge clk);
    m_rvalid = 0; m_rlast = 0; s_rready = 0;
  endtask

  // R1, R2: idle outputs after reset, free addresses pass in the same cycle
  task automatic t_basic();
    @(negedge clk);
    chk("R1", "m_awvalid idle", m_awvalid, 0);
    chk("R1", "m_arvalid idle", m_arvalid, 0);
    s_awvalid = 1; s_awid = 4'd3; s_awaddr = 32'hCAFE0010; m_awready = 0;
    #1 chk("R2", "m_awvalid", m_awvalid, 1);
    chk("R2", "m_awaddr", m_awaddr, 32'hCAFE0010);
    chk("R2", "m_awid", m_awid, 3);
    chk("R2", "s_awready low", s_awready, 0);
    @(negedge clk); m_awready = 1;
    #1 chk("R2", "s_awready", s_awready, 1);
    @(negedge clk); s_awvalid = 0; m_awready = 0;
    b_hs(3);
  endtask

  // R3, R5, R6: read waits for same-ID write response only
  task automatic t_read_waits();
    aw_hs(5, "R6");
    aw_hs(5, "R6");
    @(negedge clk);
    s_arvalid = 1; s_arid = 4'd6; s_araddr = 32'h66; m_arready = 1;
    #1 chk("R5", "other-ID read passes", m_arvalid, 1);
    @(negedge clk); s_arvalid = 0; m_arready = 0;
    r_hs(6, 1);
    @(negedge clk);
    s_arvalid = 1; s_arid = 4'd5; s_araddr = 32'h55; m_arready = 1;
    #1 chk("R3", "m_arvalid held", m_arvalid, 0);
    chk("R3", "s_arready held", s_arready, 0);
    b_hs(5);
    #1 chk("R3", "still held, one write open", m_arvalid, 0);
    b_hs(5);
    #1 chk("R3", "released after last response", m_arvalid, 1);
    chk("R3", "s_arready released", s_arready, 1);
    @(negedge clk); s_arvalid = 0; m_arready = 0;
    r_hs(5, 1);
  endtask

  // R4: write waits for the final read beat, not an earlier beat
  task automatic t_write_waits();
    ar_hs(2, "R4");
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd2; s_awaddr = 32'h22; m_awready = 1;
    #1 chk("R4", "m_awvalid held", m_awvalid, 0);
    r_hs(2, 0);
    #1 chk("R4", "held after non-last beat", m_awvalid, 0);
    r_hs(2, 1);
    #1 chk("R4", "released after last beat", m_awvalid, 1);
    @(negedge clk); s_awvalid = 0; m_awready = 0;
    b_hs(2);
  endtask

  // R7: same-cycle, same-ID arrival goes to the write
  task automatic t_collision();
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd9; s_awaddr = 32'h99; m_awready = 1;
    s_arvalid = 1; s_arid = 4'd9; s_araddr = 32'h9A; m_arready = 1;
    #1 chk("R7", "write wins", m_awvalid, 1);
    chk("R7", "read held", m_arvalid, 0);
    @(negedge clk); s_awvalid = 0; m_awready = 0;
    #1 chk("R7", "read held behind write", m_arvalid, 0);
    b_hs(9);
    #1 chk("R7", "read goes after response", m_arvalid, 1);
    @(negedge clk); s_arvalid = 0; m_arready = 0;
    r_hs(9, 1);
  endtask

  // R8: a read already shown to the controller is not withdrawn
  task automatic t_keep_valid();
    @(negedge clk);
    s_arvalid = 1; s_arid = 4'd4; s_araddr = 32'hA4A4; m_arready = 0;
    #1 chk("R8", "read shown", m_arvalid, 1);
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd4; s_awaddr = 32'hB4; m_awready = 1;
    #1 chk("R8", "read kept", m_arvalid, 1);
    chk("R8", "read addr stable", m_araddr, 32'hA4A4);
    chk("R8", "write held", m_awvalid, 0);
    @(negedge clk); m_arready = 1;
    #1 chk("R8", "read still kept", m_arvalid, 1);
    @(negedge clk); s_arvalid = 0; m_arready = 0;
    #1 chk("R8", "write held by open read", m_awvalid, 0);
    r_hs(4, 1);
    #1 chk("R8", "write goes after read", m_awvalid, 1);
    @(negedge clk); s_awvalid = 0; m_awready = 0;
    b_hs(4);
  endtask

  // R9: saturation of the write count for one ID
  task automatic t_saturate();
    for (int i = 0; i < MAX_OUT; i++) aw_hs(7, "R9");
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd7; s_awaddr = 32'h77; m_awready = 1;
    #1 chk("R9", "write held at limit", m_awvalid, 0);
    chk("R9", "s_awready at limit", s_awready, 0);
    b_hs(7);
    #1 chk("R9", "write goes below limit", m_awvalid, 1);
    @(negedge clk); s_awvalid = 0; m_awready = 0;
    for (int i = 0; i < MAX_OUT; i++) b_hs(7);
  endtask

  // R10: W, B and R channels pass through
  task automatic t_pass();
    @(negedge clk);
    s_wvalid = 1; s_wdata = 32'hDEAD_BEEF; s_wlast = 1; m_wready = 1;
    m_bvalid = 1; m_bid = 4'd12; m_bresp = 2'b10; s_bready = 0;
    m_rvalid = 1; m_rid = 4'd13; m_rdata = 32'h1234_5678; m_rresp = 2'b01; m_rlast = 0; s_rready = 1;
    #1 chk("R10", "m_wvalid", m_wvalid, 1);
    chk("R10", "m_wdata", m_wdata, 32'hDEAD_BEEF);
    chk("R10", "m_wlast", m_wlast, 1);
    chk("R10", "s_wready", s_wready, 1);
    chk("R10", "s_bvalid", s_bvalid, 1);
    chk("R10", "s_bid", s_bid, 12);
    chk("R10", "s_bresp", s_bresp, 2'b10);
    chk("R10", "m_bready", m_bready, 0);
    chk("R10", "s_rvalid", s_rvalid, 1);
    chk("R10", "s_rdata", s_rdata, 32'h1234_5678);
    chk("R10", "s_rid/rresp", {s_rid, s_rresp}, {4'd13, 2'b01});
    chk("R10", "m_rready", m_rready, 1);
    @(negedge clk);
    s_wvalid = 0; s_wlast = 0; m_wready = 0; m_bvalid = 0;
    m_rvalid = 0; s_rready = 0;
  endtask

  // R1: reset clears open work
  task automatic t_reset_clear();
    aw_hs(1, "R1");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    s_arvalid = 1; s_arid = 4'd1; s_araddr = 32'h11; m_arready = 1;
    #1 chk("R1", "read free after reset", m_arvalid, 1);
    @(negedge clk); s_arvalid = 0; m_arready = 0;
    r_hs(1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_basic();
    t_read_waits();
    t_write_waits();
    t_collision();
    t_keep_valid();
    t_saturate();
    t_pass();
    t_reset_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule